// File: doc/BRIEF.md
# Latching intruder alarm controller

A clocked controller that watches a set of intrusion sensors and drives a latched alarm output together with a blinking "armed" lamp. Each sensor and the manual clear input first pass through a two-flop synchroniser. The sensors then go to a rising-edge detector. A single-cycle edge pulse on any sensor sets the alarm latch. The latch is released by the manual clear input, or by an on-delay timer once the alarm has been high for a fixed time.

While the alarm is low, a slow periodic generator sends a short high pulse to the armed lamp. The generator is held at the start of its period while the alarm is high, so the lamp stays dark during an alarm. Because the sensors are edge-triggered, a sensor that is still asserted when the alarm drops cannot set the alarm again. It must first go low and then rise again. All time intervals are parameters in milliseconds and are converted to clock ticks from a clock-frequency parameter.

Top module: `alarm_ctrl`

## Requirements
- R1: A low-to-high transition on any one or more sensor inputs sets `alarm_o`. The output goes high on the third rising clock edge after the input changes (two synchroniser stages plus the latch).
- R2: Once set, `alarm_o` stays high while `clear_i` is low and the timeout has not expired, whatever the sensors do.
- R3: `clear_i` high clears `alarm_o` with the same three-edge latency.
- R4: `alarm_o` clears by itself after exactly TIMEOUT_MS*CLK_HZ/1000 consecutive high cycles, and each new alarm gets the full period.
- R5: A sensor that is held high across a clear or a timeout does not set the alarm again until it falls and rises again.
- R6: `armed_o` is low in every cycle in which `alarm_o` is high.
- R7: While `alarm_o` is low, `armed_o` is high for the first FLASH_ON_MS ticks of every FLASH_PERIOD_MS-tick period. The period restarts at its high phase on reset release and in the first cycle after the alarm drops.
- R8: Sensors that are already high when reset is released do not set the alarm.
- R9: If a clear and a sensor edge reach the latch in the same cycle, the clear wins and `alarm_o` stays low.
- R10: During and straight after reset, `alarm_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sensor_i | input | NUM_SENSORS | Asynchronous sensor levels, active high |
| clear_i | input | 1 | Asynchronous manual clear, active high |
| alarm_o | output | 1 | Latched alarm |
| armed_o | output | 1 | Blinking armed lamp |

## Verification
A table of sensor and clear patterns sets the alarm from each sensor alone. It also sets the alarm from a second sensor rising while another is already held, which separates true edge detection from level sensing. It then clears the alarm while a sensor stays high, which shows whether a held level can set the latch again. Directed runs cover the following:
- sensors held through reset release;
- a clear arriving together with an edge, which shows the priority;
- a timed alarm whose high duration is counted to the cycle;
- the lamp pattern after reset and after a timeout, which shows whether the period restarts.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int unsigned SYNC_STAGES = 2;

  function automatic int unsigned ms_ticks(input int unsigned hz, input int unsigned ms);
    int unsigned t;
    t = (hz / 1000) * ms;
    return (t == 0) ? 1 : t;
  endfunction
endpackage

// File: rtl/alarm_sync.sv
module alarm_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[g] <= '0;
        else if (g == 0) stage_q[g] <= async_i;
        else stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/alarm_edge.sv
module alarm_edge #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned SETTLE = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] level_i,
  output logic [WIDTH-1:0] pulse_o
);
  localparam int unsigned CW = $clog2(SETTLE + 1);

  logic [WIDTH-1:0] prev_q;
  logic [CW-1:0]    settle_q;
  logic             ready;

  assign ready = (settle_q == CW'(SETTLE));

  // prev tracks level from reset so a level already high never looks like an edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q   <= '0;
      settle_q <= '0;
    end else begin
      prev_q <= level_i;
      if (!ready) settle_q <= settle_q + 1'b1;
    end
  end

  assign pulse_o = ready ? (level_i & ~prev_q) : '0;

  assert_edge_needs_low_before_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|pulse_o) |-> ((pulse_o & $past(level_i)) == '0));
endmodule

// File: rtl/alarm_ontimer.sv
module alarm_ontimer #(
  parameter int unsigned TICKS = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic done_o
);
  localparam int unsigned CW = $clog2(TICKS + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (cnt_q != CW'(TICKS - 1)) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = run_i && (cnt_q == CW'(TICKS - 1));

  assert_timer_in_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CW'(TICKS));
  assert_timer_fresh_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_q == '0));
endmodule

// File: rtl/alarm_flasher.sv
module alarm_flasher #(
  parameter int unsigned ON_TICKS     = 1,
  parameter int unsigned PERIOD_TICKS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic pulse_o
);
  localparam int unsigned CW = $clog2(PERIOD_TICKS + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (!en_i) cnt_q <= '0;
    else if (cnt_q == CW'(PERIOD_TICKS - 1)) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end

  assign pulse_o = en_i && (cnt_q < CW'(ON_TICKS));

  assert_flash_in_period_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CW'(PERIOD_TICKS));
  assert_flash_restart_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(en_i) |-> pulse_o);
endmodule

// File: rtl/alarm_ctrl.sv
module alarm_ctrl #(
  parameter int unsigned NUM_SENSORS     = 3,
  parameter int unsigned CLK_HZ          = 50_000_000,
  parameter int unsigned TIMEOUT_MS      = 10_000,
  parameter int unsigned FLASH_ON_MS     = 100,
  parameter int unsigned FLASH_PERIOD_MS = 2_000
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NUM_SENSORS-1:0] sensor_i,
  input  logic                   clear_i,
  output logic                   alarm_o,
  output logic                   armed_o
);
  import alarm_pkg::*;

  localparam int unsigned TIMEOUT_TICKS = ms_ticks(CLK_HZ, TIMEOUT_MS);
  localparam int unsigned ON_TICKS      = ms_ticks(CLK_HZ, FLASH_ON_MS);
  localparam int unsigned PERIOD_TICKS  = ms_ticks(CLK_HZ, FLASH_PERIOD_MS);

  logic [NUM_SENSORS-1:0] sens_s;
  logic [NUM_SENSORS-1:0] set_pulse;
  logic                   clr_s;
  logic                   tmo_done;
  logic                   alarm_q;
  logic                   flash;

  alarm_sync #(.WIDTH(NUM_SENSORS + 1), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i({clear_i, sensor_i}),
    .sync_o ({clr_s, sens_s})
  );

  alarm_edge #(.WIDTH(NUM_SENSORS), .SETTLE(SYNC_STAGES + 1)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .level_i(sens_s),
    .pulse_o(set_pulse)
  );

  alarm_ontimer #(.TICKS(TIMEOUT_TICKS)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (alarm_q),
    .done_o(tmo_done)
  );

  // reset terms dominate set
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) alarm_q <= 1'b0;
    else if (clr_s || tmo_done) alarm_q <= 1'b0;
    else if (|set_pulse) alarm_q <= 1'b1;
  end

  alarm_flasher #(.ON_TICKS(ON_TICKS), .PERIOD_TICKS(PERIOD_TICKS)) u_flash (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (!alarm_q),
    .pulse_o(flash)
  );

  assign alarm_o = alarm_q;
  assign armed_o = flash && !alarm_q;

  assert_set_on_edge_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|set_pulse) && !clr_s && !tmo_done) |=> alarm_o);
  assert_rise_has_cause_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(alarm_o) |-> $past(|set_pulse));
  assert_clear_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_s |=> !alarm_o);
  assert_timeout_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_done |=> !alarm_o);
  assert_lamp_dark_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_o |-> !armed_o);
endmodule

// File: tb/alarm_ctrl_test.sv
module alarm_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int TMO = 40;
  localparam int ON = 2;
  localparam int PER = 8;
  localparam int NV = 13;
  // {sensor[2:0], clear, expected alarm}
  localparam logic [4:0] VECS [NV] = '{
    5'b000_0_0, 5'b001_0_1, 5'b000_0_1, 5'b000_1_0, 5'b000_0_0,
    5'b010_0_1, 5'b010_1_0, 5'b010_0_0, 5'b000_0_0, 5'b100_0_1,
    5'b100_1_0, 5'b110_0_1, 5'b110_1_0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] sens = '0;
  logic clr = 1'b0;
  logic alarm, armed;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  alarm_ctrl #(.NUM_SENSORS(3), .CLK_HZ(1000), .TIMEOUT_MS(TMO),
               .FLASH_ON_MS(ON), .FLASH_PERIOD_MS(PER)) uut (
    .clk_i(clk), .rst_ni(rst_n), .sensor_i(sens), .clear_i(clr),
    .alarm_o(alarm), .armed_o(armed));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    cyc(100000);
    if (!done) begin
      check(0, "watchdog", 0, 1);
      finish_run();
    end
  end

  initial begin
    int n;
    // R10 reset state; R7 lamp lit at start of period
    @(negedge clk);
    check(alarm == 1'b0, "R10", alarm, 0);
    cyc(2);
    rst_n = 1'b1;
    for (int k = 0; k < 2*PER; k++) begin
      check(armed == ((k % PER) < ON), "R7 pattern", armed, (k % PER) < ON);
      cyc(1);
    end

    // table walk: R1 R2 R3 R5
    for (int v = 0; v < NV; v++) begin
      sens = VECS[v][4:2];
      clr  = VECS[v][1];
      cyc(4);
      check(alarm == VECS[v][0], $sformatf("R1/R2/R3/R5 vec %0d", v), alarm, VECS[v][0]);
    end
    sens = '0; clr = 1'b0;
    cyc(4);

    // R1 latency: high exactly after third edge
    sens = 3'b001;
    cyc(2);
    check(alarm == 1'b0, "R1 latency early", alarm, 0);
    cyc(1);
    check(alarm == 1'b1, "R1 latency", alarm, 1);
    clr = 1'b1; sens = '0;
    cyc(4);
    clr = 1'b0;
    cyc(2);

    // R8 sensors high through reset release
    rst_n = 1'b0;
    sens = 3'b111;
    cyc(2);
    rst_n = 1'b1;
    cyc(10);
    check(alarm == 1'b0, "R8", alarm, 0);
    sens = 3'b011;
    cyc(2);
    sens = 3'b111;
    cyc(4);
    check(alarm == 1'b1, "R1 after power-up", alarm, 1);
    clr = 1'b1; sens = '0;
    cyc(4);
    clr = 1'b0;
    cyc(2);

    // R9 clear together with edge
    sens = 3'b100; clr = 1'b1;
    cyc(4);
    check(alarm == 1'b0, "R9 coincident", alarm, 0);
    clr = 1'b0;
    cyc(4);
    check(alarm == 1'b0, "R9 no later set", alarm, 0);
    sens = '0;
    cyc(4);

    // R4 timeout, R6 dark lamp, R5 no retrigger, R7 restart
    sens = 3'b001;
    cyc(3);
    check(alarm == 1'b1, "R4 start", alarm, 1);
    n = 0;
    while (alarm && n < 200) begin
      check(armed == 1'b0, "R6", armed, 0);
      n++;
      cyc(1);
    end
    check(n == TMO, "R4 duration", n, TMO);
    for (int k = 0; k < PER; k++) begin
      check(armed == (k < ON), "R7 restart", armed, k < ON);
      cyc(1);
    end
    check(alarm == 1'b0, "R5 held after timeout", alarm, 0);
    sens = '0;
    cyc(3);
    sens = 3'b001;
    cyc(4);
    check(alarm == 1'b1, "R5 new edge", alarm, 1);
    // R4 each alarm gets full period: clear partway then retime
    clr = 1'b1;
    cyc(4);
    clr = 1'b0; sens = '0;
    cyc(3);
    sens = 3'b010;
    cyc(3);
    n = 0;
    while (alarm && n < 200) begin
      n++;
      cyc(1);
    end
    check(n == TMO, "R4 second duration", n, TMO);

    done = 1;
    finish_run();
  end
endmodule